// File: doc/BRIEF.md
# Inter-Frame Silence and Reply Timer

This block sits beside the receive path of a byte-serial field bus and uses line silence to find frame boundaries. A one-cycle strobe from the receiving UART marks each byte that arrives. Each strobe opens a frame, or keeps the current frame open, and restarts a silence counter. When the line has been quiet for three and a half character times, the block raises a single-cycle end-of-frame pulse and closes the frame. Short pauses between bytes of the same frame, typically one or two bit times, do not close it.

A second, independent counter watches for a missing reply. A pulse on `req_sent` marks the end of an outgoing request and arms this counter. The first received byte disarms it. If the configured number of character times passes with no byte, the block raises a one-cycle timeout pulse. One character time is 11 bit times, and a bit time is a run-time number of clock cycles. The bit-time setting and the reply window are taken from the inputs only while the bus is quiet.

Top module: `frame_gap_timer`

## Requirements
- R1: After reset, `frame_open`, `frame_end`, `reply_armed` and `reply_timeout` are all low.
- R2: A cycle with `rx_byte` high sets `frame_open` from the next cycle and restarts the silence count at zero.
- R3: With `frame_open` high, `frame_end` goes high for exactly one cycle, ceil(38.5 × B) clock edges after the edge that sampled the last strobe, where B is the sampled bit time. `frame_open` goes low in that same cycle.
- R4: Strobes that are closer together than the gap threshold keep `frame_open` high and produce no `frame_end`.
- R5: A cycle with `req_sent` high sets `reply_armed` from the next cycle and restarts the reply count. A new `req_sent` while the counter is armed restarts the window, and `req_sent` takes priority over a strobe in the same cycle.
- R6: A strobe while the counter is armed, with no `req_sent` in that cycle, clears `reply_armed` and no `reply_timeout` follows.
- R7: If no strobe arrives, `reply_timeout` goes high for exactly one cycle, C × 11 × B edges after the arming edge, where C is the sampled character count. `reply_armed` goes low in that same cycle.
- R8: `cfg_clks_per_bit` and `cfg_reply_chars` are sampled only on edges where `frame_open` and `reply_armed` are both low. Changes to them while a frame is open or a reply is armed have no effect on the windows that are running.
- R9: A value of zero on `cfg_clks_per_bit` or on `cfg_reply_chars` is treated as one. With both inputs at zero, the gap is 39 cycles and the reply window is 11 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 1 | One-cycle strobe for each received byte |
| req_sent | input | 1 | One-cycle pulse when a request has been sent |
| cfg_clks_per_bit | input | CPB_W | Clock cycles per bit time (0 means 1) |
| cfg_reply_chars | input | RCH_W | Reply window in character times (0 means 1) |
| frame_open | output | 1 | A frame is in progress |
| frame_end | output | 1 | One-cycle pulse at the end of a frame |
| reply_armed | output | 1 | The reply counter is waiting for a byte |
| reply_timeout | output | 1 | One-cycle pulse when no reply arrived in time |

## Verification
The bench builds the block with CPB_W = 8 and RCH_W = 6. With these widths it can use bit times of 0, 2, 3 and 10 cycles. Gap thresholds therefore range from 39 to 385 cycles, including the odd-product case where the threshold is rounded up (116 for B = 3). Reply windows range from 11 to 660 cycles. All of these fit into short runs, so each exact edge count is measured rather than bounded. A behavioural model written with integers runs alongside the block and is compared with it on every clock. Directed scenarios then measure latencies across configuration changes, re-arming, and a byte that cancels the reply window.

// File: rtl/frame_gap_timer.sv
module frame_gap_timer #(
  parameter int CPB_W         = 16,
  parameter int RCH_W         = 8,
  parameter int BITS_PER_CHAR = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_byte,
  input  logic             req_sent,
  input  logic [CPB_W-1:0] cfg_clks_per_bit,
  input  logic [RCH_W-1:0] cfg_reply_chars,
  output logic             frame_open,
  output logic             frame_end,
  output logic             reply_armed,
  output logic             reply_timeout
);

  localparam int GAP_HALF_BITS = 7 * BITS_PER_CHAR;
  localparam int GTHR_W        = CPB_W + $clog2(GAP_HALF_BITS + 1);
  localparam int GP_W          = GTHR_W + 1;
  localparam int RTHR_W        = CPB_W + RCH_W + $clog2(BITS_PER_CHAR + 1);
  localparam int GTHR_RST      = (GAP_HALF_BITS + 1) / 2;
  localparam int RTHR_RST      = BITS_PER_CHAR;

  logic [CPB_W-1:0]  cpb_eff;
  logic [RCH_W-1:0]  chars_eff;
  logic [GP_W-1:0]   gap_prod;
  logic [GTHR_W-1:0] gap_thr_next, gap_thr_q, gap_cnt, gap_inc;
  logic [RTHR_W-1:0] reply_thr_next, reply_thr_q, reply_cnt, reply_inc;
  logic              bus_quiet;

  assign cpb_eff   = (cfg_clks_per_bit == '0) ? CPB_W'(1) : cfg_clks_per_bit;
  assign chars_eff = (cfg_reply_chars == '0) ? RCH_W'(1) : cfg_reply_chars;

  assign gap_prod       = GP_W'(GAP_HALF_BITS) * GP_W'(cpb_eff) + GP_W'(1);
  assign gap_thr_next   = gap_prod[GP_W-1:1];
  assign reply_thr_next = RTHR_W'(BITS_PER_CHAR) * RTHR_W'(cpb_eff) * RTHR_W'(chars_eff);

  assign bus_quiet = !frame_open && !reply_armed;
  assign gap_inc   = gap_cnt + GTHR_W'(1);
  assign reply_inc = reply_cnt + RTHR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_thr_q   <= GTHR_W'(GTHR_RST);
      reply_thr_q <= RTHR_W'(RTHR_RST);
    end else if (bus_quiet) begin
      gap_thr_q   <= gap_thr_next;
      reply_thr_q <= reply_thr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt    <= '0;
      frame_open <= 1'b0;
      frame_end  <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (rx_byte) begin
        gap_cnt    <= '0;
        frame_open <= 1'b1;
      end else if (frame_open) begin
        gap_cnt <= gap_inc;
        if (gap_inc == gap_thr_q) begin
          frame_end  <= 1'b1;
          frame_open <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_cnt     <= '0;
      reply_armed   <= 1'b0;
      reply_timeout <= 1'b0;
    end else begin
      reply_timeout <= 1'b0;
      if (req_sent) begin
        reply_cnt   <= '0;
        reply_armed <= 1'b1;
      end else if (reply_armed) begin
        if (rx_byte) begin
          reply_armed <= 1'b0;
        end else begin
          reply_cnt <= reply_inc;
          if (reply_inc == reply_thr_q) begin
            reply_timeout <= 1'b1;
            reply_armed   <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/frame_gap_timer_chk.sv
module frame_gap_timer_chk #(
  parameter int GW = 8,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_byte,
  input logic          req_sent,
  input logic          frame_open,
  input logic          frame_end,
  input logic          reply_armed,
  input logic          reply_timeout,
  input logic [GW-1:0] gap_thr_q,
  input logic [RW-1:0] reply_thr_q
);

  p_open_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte |=> frame_open);

  p_close_on_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !frame_open);

  p_single_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_no_end_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte |=> !frame_end);

  p_arm_on_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_sent |=> (reply_armed && !reply_timeout));

  p_disarm_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_armed && rx_byte && !req_sent) |=> (!reply_armed && !reply_timeout));

  p_timeout_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reply_timeout |-> !reply_armed);

  p_single_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reply_timeout |=> !reply_timeout);

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_open || reply_armed) |=> ($stable(gap_thr_q) && $stable(reply_thr_q)));

  p_thr_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_thr_q != '0) && (reply_thr_q != '0));

endmodule

bind frame_gap_timer frame_gap_timer_chk #(.GW(GTHR_W), .RW(RTHR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_byte      (rx_byte),
  .req_sent     (req_sent),
  .frame_open   (frame_open),
  .frame_end    (frame_end),
  .reply_armed  (reply_armed),
  .reply_timeout(reply_timeout),
  .gap_thr_q    (gap_thr_q),
  .reply_thr_q  (reply_thr_q)
);

// File: tb/tb_frame_gap_timer.sv
`timescale 1ns/1ps
module tb_frame_gap_timer;
  localparam int CPB_W = 8;
  localparam int RCH_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_byte = 1'b0;
  logic req_sent = 1'b0;
  logic [CPB_W-1:0] cfg_cpb = 8'd1;
  logic [RCH_W-1:0] cfg_chars = 6'd1;
  logic frame_open, frame_end, reply_armed, reply_timeout;

  always #4 clk = ~clk;

  frame_gap_timer #(.CPB_W(CPB_W), .RCH_W(RCH_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .req_sent(req_sent),
    .cfg_clks_per_bit(cfg_cpb), .cfg_reply_chars(cfg_chars),
    .frame_open(frame_open), .frame_end(frame_end),
    .reply_armed(reply_armed), .reply_timeout(reply_timeout));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  int m_open, m_end, m_armed, m_to, m_gcnt, m_rcnt, m_gthr, m_rthr;
  always @(posedge clk) begin
    int b, c, ng, nr;
    bit quiet;
    if (!rst_n) begin
      m_open = 0; m_end = 0; m_armed = 0; m_to = 0;
      m_gcnt = 0; m_rcnt = 0; m_gthr = 39; m_rthr = 11;
    end else begin
      quiet = (m_open == 0) && (m_armed == 0);
      b = (cfg_cpb == 0) ? 1 : int'(cfg_cpb);
      c = (cfg_chars == 0) ? 1 : int'(cfg_chars);
      ng = (77 * b + 1) / 2;
      nr = c * 11 * b;
      m_end = 0;
      if (rx_byte) begin m_gcnt = 0; m_open = 1; end
      else if (m_open != 0) begin
        m_gcnt++;
        if (m_gcnt == m_gthr) begin m_end = 1; m_open = 0; end
      end
      m_to = 0;
      if (req_sent) begin m_armed = 1; m_rcnt = 0; end
      else if (m_armed != 0) begin
        if (rx_byte) m_armed = 0;
        else begin
          m_rcnt++;
          if (m_rcnt == m_rthr) begin m_to = 1; m_armed = 0; end
        end
      end
      if (quiet) begin m_gthr = ng; m_rthr = nr; end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison and event timing
  int cyc = 0, last_rx = 0, last_req = 0, end_lat = -1, to_lat = -1, n_end = 0, n_to = 0;
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 frame_open", int'(frame_open), m_open);
      chk("R3 frame_end", int'(frame_end), m_end);
      chk("R5 reply_armed", int'(reply_armed), m_armed);
      chk("R7 reply_timeout", int'(reply_timeout), m_to);
      if (rx_byte) last_rx = cyc;
      if (req_sent) last_req = cyc;
      if (frame_end) begin end_lat = cyc - last_rx; n_end++; end
      if (reply_timeout) begin to_lat = cyc - last_req; n_to++; end
    end
    cyc++;
  end

  task automatic wait_n(int n); repeat (n) @(negedge clk); endtask
  task automatic send_rx;  @(negedge clk) rx_byte = 1; @(negedge clk) rx_byte = 0; endtask
  task automatic send_req; @(negedge clk) req_sent = 1; @(negedge clk) req_sent = 0; endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e0, t0;
    wait_n(4);
    chk("R1 frame_open", int'(frame_open), 0);
    chk("R1 frame_end", int'(frame_end), 0);
    chk("R1 reply_armed", int'(reply_armed), 0);
    chk("R1 reply_timeout", int'(reply_timeout), 0);
    @(negedge clk) rst_n = 1;

    // R4 / R3: eight bytes with short gaps, bit time 3
    cfg_cpb = 3; cfg_chars = 20; wait_n(2);
    e0 = n_end;
    for (int i = 0; i < 8; i++) begin send_rx(); wait_n(19); end
    chk("R4 no frame_end inside frame", n_end, e0);
    chk("R4 frame stays open", int'(frame_open), 1);
    wait_n(200);
    chk("R3 one frame_end", n_end, e0 + 1);
    chk("R3 gap latency rounded up", end_lat, 116);

    // R8: change bit time mid-frame
    send_rx(); wait_n(5); cfg_cpb = 10; wait_n(150);
    chk("R8 mid-frame change ignored", end_lat, 116);
    send_rx(); wait_n(420);
    chk("R8 new bit time after idle", end_lat, 385);

    // R7: timeout with B=2, C=3
    cfg_cpb = 2; cfg_chars = 3; wait_n(2);
    t0 = n_to;
    send_req(); wait_n(80);
    chk("R7 timeout count", n_to, t0 + 1);
    chk("R7 timeout latency", to_lat, 66);
    chk("R7 disarmed", int'(reply_armed), 0);

    // R6: byte cancels reply window
    t0 = n_to;
    send_req(); wait_n(30); send_rx();
    chk("R6 disarmed by byte", int'(reply_armed), 0);
    wait_n(120);
    chk("R6 no timeout", n_to, t0);

    // R5: re-arm restarts window
    t0 = n_to;
    send_req(); wait_n(40); send_req(); wait_n(100);
    chk("R5 single timeout after rearm", n_to, t0 + 1);
    chk("R5 rearm latency", to_lat, 66);

    // R9: zero config treated as one
    cfg_cpb = 0; cfg_chars = 0; wait_n(2);
    send_rx(); wait_n(60);
    chk("R9 gap with zero bit time", end_lat, 39);
    send_req(); wait_n(20);
    chk("R9 reply with zero config", to_lat, 11);

    // R8: reply window fixed while armed
    cfg_cpb = 2; cfg_chars = 3; wait_n(2);
    send_req(); wait_n(5); cfg_chars = 50; wait_n(100);
    chk("R8 reply change ignored", to_lat, 66);

    wait_n(5);
    finish_run();
  end
endmodule